// File: doc/BRIEF.md
# Sequential Break Sequencer

This block turns four per-cycle channel match pulses (channels A, B, C and D) into a break request. A two-bit mode value chooses how the pulses are combined. In the independent mode, every channel acts alone: a match raises a break and sets that channel's flag. In the three ordered modes, the block follows a chain of channels that always ends at D. The chain is C→D, B→C→D or A→B→C→D. A break is requested only when D matches after every earlier channel in the chain has matched, in the right order.

Progress through a chain is kept in a stage counter. The counter moves by at most one stage per cycle, and only on a match of the channel it currently expects. When neighbouring channels fire in the same cycle, only the stage that was still pending is credited. Each channel has a sticky flag. Software clears the flags through a write-one-to-clear input. The mode value is loaded through a write strobe, and every write restarts the chain.

Top module: `seqb_top`

## Requirements
- R1: After reset, `break_o` is 0, `flags_o` is 0000 and the mode is 00 (independent).
- R2: In mode 00, a match on any channel sets that channel's flag and drives `break_o` high in the next cycle. Match bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R3: In mode 01, a match on C followed by a later match on D raises `break_o` one cycle after the D match.
- R4: In mode 10, matches on B, then C, then D raise a break one cycle after the D match.
- R5: In mode 11, matches on A, then B, then C, then D raise a break one cycle after the D match.
- R6: When an ordered break fires, the flag of every channel in the chain is 1 in the same cycle as `break_o`. Intermediate stage matches set no flag.
- R7: When the expected channel and the next channel in the chain match in the same cycle, only the expected channel is credited. The chain advances by one stage and the later match is dropped.
- R8: Once a stage is met, a cycle in which that stage's channel and the next channel both match credits the next channel. When C and D match together after C was met, the break is raised.
- R9: In the ordered modes, a match on a channel that is not the expected stage leaves progress unchanged. This includes channels outside the chain.
- R10: An ordered break is a one-cycle pulse. After it, the chain restarts at its first stage, so a D match alone does not raise another break.
- R11: A mode write (`mode_wr_i` = 1) loads `mode_i` and restarts the chain. Matches presented in the write cycle have no effect on the break or the flags.
- R12: A 1 on `flag_clr_i[i]` clears flag i in the next cycle. If the flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Loads `mode_i` and restarts the chain |
| mode_i | input | 2 | Mode value: 00 independent, 01 C→D, 10 B→C→D, 11 A→B→C→D |
| match_i | input | 4 | Per-cycle channel match pulses, bit 0 = A to bit 3 = D |
| flag_clr_i | input | 4 | Write-one-to-clear for the sticky flags |
| break_o | output | 1 | Break request, registered |
| flags_o | output | 4 | Sticky per-channel match flags |

## Verification
Neighbouring channels can match in the same cycle, so advancing the expected stage and crediting the next stage can fall on one clock edge. The bench provokes this directly: for every ordered mode, it first drives the chain to each possible stage, then applies all sixteen match patterns at once. It judges the result against a stage count worked out by an independent model. A second overlap is a flag being set and cleared in the same cycle, or a mode write that coincides with a finishing D match. Both are driven on purpose, and also appear in a long pseudo-random stream.

// File: rtl/seqb_pkg.sv
package seqb_pkg;
  // Default channel count; must be a power of two so the mode field spans all chain lengths
  localparam int unsigned SEQB_NCH = 4;
  // Mode value that selects independent channels
  localparam int unsigned SEQB_MODE_INDEP = 0;
endpackage

// File: rtl/seqb_mode_reg.sv
module seqb_mode_reg #(
  parameter int unsigned MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [MW-1:0] mode_i,
  output logic [MW-1:0] mode_q
);
  logic [MW-1:0] mode_d;
  logic          mode_en;

  always_comb begin
    mode_en = wr_i;
    mode_d  = mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end
endmodule

// File: rtl/seqb_chain.sv
module seqb_chain #(
  parameter int unsigned NCH = 4,
  parameter int unsigned MW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [MW-1:0]  mode_q,
  input  logic           mode_wr,
  input  logic [NCH-1:0] match,
  output logic           hit,
  output logic           seq_done
);
  import seqb_pkg::*;

  localparam logic [MW-1:0] LAST_CH = MW'(NCH - 1);

  logic [MW-1:0] stg_q, stg_d;
  logic          stg_en;
  logic [MW-1:0] first_ch, exp_ch;
  logic          exp_hit, is_last, ordered;

  // Work out which channel is expected next and whether it matched
  always_comb begin
    ordered  = (mode_q != MW'(SEQB_MODE_INDEP));
    first_ch = LAST_CH - mode_q;
    exp_ch   = first_ch + stg_q;
    exp_hit  = match[exp_ch];
    is_last  = (exp_ch == LAST_CH);
  end

  // Next stage: the counter steps at most once per cycle
  always_comb begin
    stg_en = mode_wr | (ordered & exp_hit);
    if (mode_wr || is_last) stg_d = '0;
    else                    stg_d = stg_q + MW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stg_q <= '0;
    else if (stg_en) stg_q <= stg_d;
  end

  always_comb begin
    seq_done = ~mode_wr & ordered & exp_hit & is_last;
    if (mode_wr)      hit = 1'b0;
    else if (ordered) hit = seq_done;
    else              hit = |match;
  end

  // R9
  stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_q <= mode_q);

  // R11
  wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (stg_q == '0));

  // R7
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> (stg_q == $past(stg_q)) || (stg_q == $past(stg_q) + MW'(1)) || (stg_q == '0));

  // R10
  restart_after_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (stg_q == '0));
endmodule

// File: rtl/seqb_flags.sv
module seqb_flags #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] flags_q
);
  logic [NCH-1:0] flags_d;
  logic           flags_en;

  always_comb begin
    flags_en = (|set_i) | (|clr_i);
    flags_d  = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  // R12
  set_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & clr_i)) |=> ((flags_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

  // R12
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/seqb_top.sv
module seqb_top #(
  parameter int unsigned NCH = seqb_pkg::SEQB_NCH,
  localparam int unsigned MW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr_i,
  input  logic [MW-1:0]  mode_i,
  input  logic [NCH-1:0] match_i,
  input  logic [NCH-1:0] flag_clr_i,
  output logic           break_o,
  output logic [NCH-1:0] flags_o
);
  import seqb_pkg::*;

  logic [MW-1:0]  mode_q;
  logic           hit, seq_done;
  logic           brk_q, brk_d;
  logic [NCH-1:0] chain_mask, set_vec;
  logic [MW-1:0]  first_ch;
  logic           ordered;

  seqb_mode_reg #(.MW(MW)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (mode_wr_i),
    .mode_i (mode_i),
    .mode_q (mode_q)
  );

  seqb_chain #(.NCH(NCH), .MW(MW)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .mode_wr  (mode_wr_i),
    .match    (match_i),
    .hit      (hit),
    .seq_done (seq_done)
  );

  always_comb begin
    ordered  = (mode_q != MW'(SEQB_MODE_INDEP));
    first_ch = MW'(NCH - 1) - mode_q;
  end

  // One mask bit per channel: set when the channel belongs to the selected chain
  for (genvar i = 0; i < NCH; i++) begin : g_mask
    assign chain_mask[i] = ordered && (MW'(i) >= first_ch);
  end

  always_comb begin
    if (mode_wr_i)     set_vec = '0;
    else if (!ordered) set_vec = match_i;
    else if (seq_done) set_vec = chain_mask;
    else               set_vec = '0;
  end

  seqb_flags #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (flag_clr_i),
    .flags_q (flags_o)
  );

  always_comb brk_d = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= brk_d;
  end

  assign break_o = brk_q;

  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && ordered) |=> !brk_q);

  // R6
  chain_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && ordered) |-> ((flags_o & chain_mask) == chain_mask));

  // R2
  indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ordered && !mode_wr_i && (|match_i)) |=> brk_q);

  // R11
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> !brk_q);
endmodule

// File: tb/tb_seqb_top.sv
module tb_seqb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [3:0] match_i = 4'b0;
  logic [3:0] flag_clr_i = 4'b0;
  logic       break_o;
  logic [3:0] flags_o;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  // Reference state kept by the bench
  int         m_mode = 0;
  int         m_stg = 0;
  logic [3:0] m_flags = 4'b0;
  logic       m_brk = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  seqb_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr_i  (mode_wr_i),
    .mode_i     (mode_i),
    .match_i    (match_i),
    .flag_clr_i (flag_clr_i),
    .break_o    (break_o),
    .flags_o    (flags_o)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  task automatic expect_out(input string tag, input logic eb, input logic [3:0] ef);
    vecs++;
    if (break_o !== eb || flags_o !== ef) begin
      errs++;
      $display("FAIL %s: break=%b flags=%b expected break=%b flags=%b", tag, break_o, flags_o, eb, ef);
    end
  endtask

  // Next-state model written from the requirement list
  task automatic model_step(input logic wr, input logic [1:0] md, input logic [3:0] mt, input logic [3:0] cl);
    logic [3:0] f;
    int ex;
    f = m_flags & ~cl;
    m_brk = 1'b0;
    if (wr) begin
      m_mode = md;
      m_stg = 0;
    end else if (m_mode == 0) begin
      m_brk = |mt;
      f = f | mt;
    end else begin
      ex = 3 - m_mode + m_stg;
      if (mt[ex]) begin
        if (ex == 3) begin
          m_brk = 1'b1;
          m_stg = 0;
          for (int i = 3 - m_mode; i < 4; i++) f[i] = 1'b1;
        end else begin
          m_stg = m_stg + 1;
        end
      end
    end
    m_flags = f;
  endtask

  task automatic step(input string tag, input logic wr, input logic [1:0] md, input logic [3:0] mt, input logic [3:0] cl);
    mode_wr_i = wr;
    mode_i = md;
    match_i = mt;
    flag_clr_i = cl;
    model_step(wr, md, mt, cl);
    @(negedge clk);
    expect_out(tag, m_brk, m_flags);
    mode_wr_i = 1'b0;
    match_i = 4'b0;
    flag_clr_i = 4'b0;
  endtask

  task automatic go(input string tag, input logic [3:0] mt);
    step(tag, 1'b0, 2'b00, mt, 4'b0);
  endtask

  task automatic set_mode(input string tag, input logic [1:0] md);
    step(tag, 1'b1, md, 4'b0, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 1'b0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 idle after reset", 1'b0, 4'b0000);

    // R2 independent channels
    go("R2", 4'b0101);
    expect_out("R2 explicit", 1'b1, 4'b0101);
    go("R2", 4'b0000);
    expect_out("R2 pulse ends", 1'b0, 4'b0101);
    step("R12", 1'b0, 2'b00, 4'b0, 4'b1111);
    expect_out("R12 clear", 1'b0, 4'b0000);

    // R3 C then D
    set_mode("R11", 2'b01);
    go("R3", 4'b0100);
    expect_out("R3 stage only", 1'b0, 4'b0000);
    go("R3", 4'b1000);
    expect_out("R3 break", 1'b1, 4'b1100);

    // R9 out of order and out of chain
    set_mode("R11", 2'b01);
    go("R9", 4'b1000);
    go("R9", 4'b0011);
    expect_out("R9 ignored", 1'b0, 4'b0000);
    go("R9", 4'b0100);
    go("R9", 4'b0001);
    go("R9", 4'b1000);
    expect_out("R9 break", 1'b1, 4'b1100);

    // R10 one pulse, restart
    go("R10", 4'b0000);
    expect_out("R10 pulse ends", 1'b0, 4'b1100);
    go("R10", 4'b1000);
    expect_out("R10 no rebreak", 1'b0, 4'b1100);

    // R4 B C D
    set_mode("R11", 2'b10);
    go("R4", 4'b0010);
    go("R4", 4'b0100);
    go("R4", 4'b1000);
    expect_out("R4 break", 1'b1, 4'b1110);

    // R5 and R6 A B C D
    set_mode("R11", 2'b11);
    go("R5", 4'b0001);
    go("R5", 4'b0010);
    expect_out("R6 no flags mid-chain", 1'b0, 4'b0000);
    go("R5", 4'b0100);
    go("R5", 4'b1000);
    expect_out("R5 break", 1'b1, 4'b1111);

    // R7 same-cycle neighbours, earlier unmet
    set_mode("R11", 2'b11);
    go("R7", 4'b0011);
    go("R7", 4'b0100);
    go("R7", 4'b0010);
    go("R7", 4'b1100);
    expect_out("R7 C credited not D", 1'b0, 4'b0000);
    go("R7", 4'b1000);
    expect_out("R7 break", 1'b1, 4'b1111);

    // R8 same-cycle neighbours, earlier met
    set_mode("R11", 2'b01);
    go("R8", 4'b0100);
    go("R8", 4'b1100);
    expect_out("R8 C+D after C", 1'b1, 4'b1100);
    set_mode("R11", 2'b10);
    go("R8", 4'b0010);
    go("R8", 4'b0110);
    go("R8", 4'b1100);
    expect_out("R8 chain B C D", 1'b1, 4'b1110);

    // R11 write with a finishing match
    set_mode("R11", 2'b01);
    go("R11", 4'b0100);
    step("R11", 1'b1, 2'b01, 4'b1000, 4'b0);
    expect_out("R11 write masks D", 1'b0, 4'b0000);
    go("R11", 4'b1000);
    expect_out("R11 restarted", 1'b0, 4'b0000);

    // R12 set beats clear
    set_mode("R11", 2'b00);
    go("R12", 4'b1100);
    step("R12", 1'b0, 2'b00, 4'b0000, 4'b0100);
    expect_out("R12 partial clear", 1'b0, 4'b1000);
    step("R12", 1'b0, 2'b00, 4'b0001, 4'b0001);
    expect_out("R12 set wins", 1'b1, 4'b1001);

    // Every stage x every match pattern
    for (int m = 1; m < 4; m++) begin
      for (int k = 0; k <= m; k++) begin
        for (int p = 0; p < 16; p++) begin
          set_mode("R7 sweep", 2'(m));
          for (int j = 0; j < k; j++) go("R8 sweep", 4'(1 << (3 - m + j)));
          go("R7 sweep", 4'(p));
          go("R9 sweep", 4'b1000);
        end
      end
    end

    // Pseudo-random stream
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R3 stream", (lfsr[11:8] == 4'hF), lfsr[1:0], lfsr[3:0] & lfsr[7:4],
           (lfsr[15:12] == 4'h0) ? 4'hF : 4'h0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule